// File: doc/BRIEF.md
# Debug Trace Buffer Readout

This block is the storage and readout side of an on-chip debug trace buffer. It holds eight 16-bit words. A host reaches them one byte at a time through two read-only data registers on an 8-bit register bus. A select input picks the upper-byte register or the lower-byte register. Read data is combinational from the word at the head of the buffer.

When the capture flag is set, each capture strobe stores one trace word. In byte-event mode only the low byte is kept. The flag drops by itself once the eighth word is stored, or when a clear pulse arrives.

When the flag is clear, each lower-byte read returns the head and shifts the buffer by one word. On the same edge, the address of the most recently fetched opcode is pushed into the tail. A host that polls the buffer this way gets a profile of execution delayed by eight samples.

Top module: `trace_fifo_rd`

## Requirements
- R1: After reset the capture flag is clear and all eight words are 0x0000, so the first eight profiling reads return 0x0000.
- R2: A read with `reg_sel`=1 returns bits 15:8 of the head word and never moves the buffer.
- R3: A read with `reg_sel`=0 returns bits 7:0 of the head word. When the capture flag is clear, the buffer then advances by one word on that edge.
- R4: Write strobes to either data register, whatever their data, leave the stored words unchanged.
- R5: While the flag is set, each `cap_stb` stores `cap_data` into the next word, in order from the head. The flag stays set after the first seven captures and clears on the edge that stores the eighth.
- R6: While the flag is set, a lower-byte read neither advances the buffer nor inserts an address.
- R7: While the flag is clear, a lower-byte read writes `op_addr` into the tail word. The ninth such read returns the address sampled by the first.
- R8: With `evt_mode`=1, a capture stores {8'h00, cap_data[7:0]}, and an upper-byte read returns 0x00.
- R9: `arm_clr` clears the flag on the next edge and leaves the stored words intact; it overrides `arm_set`. `arm_set` sets the flag and restarts capture at the head word.
- R10: A `cap_stb` while the flag is clear is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_set | input | 1 | Pulse that sets the capture flag |
| arm_clr | input | 1 | Pulse that clears the capture flag |
| evt_mode | input | 1 | 1 selects byte-event capture |
| cap_stb | input | 1 | Capture strobe |
| cap_data | input | 16 | Trace word to capture |
| op_addr | input | 16 | Address of the most recent opcode fetch |
| reg_sel | input | 1 | 1 selects the upper-byte register, 0 the lower-byte register |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe (ignored) |
| wr_data | input | 8 | Register write data (ignored) |
| rd_data | output | 8 | Selected byte of the head word |
| armed | output | 1 | Capture flag |

## Verification
The hardest state to reach is a partly filled buffer with the flag still set while the host reads the lower byte. The stimulus arms the buffer, captures only three words, and then issues two lower-byte reads. It expects the same head byte both times, followed by an explicit clear. The eight-sample profiling delay is observable only across long read sequences. For that reason, the stimulus changes `op_addr` on every read and checks that each returned word matches the address of eight reads earlier.

// File: rtl/trace_fifo_rd.sv
module trace_fifo_rd #(
  parameter int DEPTH = 8,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int BW   = W / 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_set,
  input  logic          arm_clr,
  input  logic          evt_mode,
  input  logic          cap_stb,
  input  logic [W-1:0]  cap_data,
  input  logic [W-1:0]  op_addr,
  input  logic          reg_sel,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [BW-1:0] wr_data,
  output logic [BW-1:0] rd_data,
  output logic          armed
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] cnt;
  logic          armed_q;
  logic [W-1:0]  head, tail;
  logic          lo_rd, cap, last;
  logic          unused_wr;

  assign head      = mem[0];
  assign tail      = mem[DEPTH-1];
  assign lo_rd     = rd_en && !reg_sel;
  assign cap       = armed_q && cap_stb && !arm_clr && !arm_set;
  assign last      = (cnt == AW'(DEPTH - 1));
  assign armed     = armed_q;
  assign unused_wr = ^{wr_en, wr_data};

  assign rd_data = reg_sel ? (evt_mode ? '0 : head[W-1:BW]) : head[BW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt     <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (arm_clr) begin
      armed_q <= 1'b0;
      cnt     <= '0;
    end else if (arm_set) begin
      armed_q <= 1'b1;
      cnt     <= '0;
    end else if (cap) begin
      mem[cnt] <= evt_mode ? {{BW{1'b0}}, cap_data[BW-1:0]} : cap_data;
      if (last) begin
        armed_q <= 1'b0;
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end else if (lo_rd && !armed_q) begin
      for (int i = 0; i < DEPTH - 1; i++) mem[i] <= mem[i+1];
      mem[DEPTH-1] <= op_addr;
    end
  end

endmodule

module trace_fifo_rd_chk #(
  parameter int DEPTH = 8,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          armed,
  input logic          arm_set,
  input logic          arm_clr,
  input logic          cap_stb,
  input logic          rd_en,
  input logic          wr_en,
  input logic          reg_sel,
  input logic [W-1:0]  op_addr,
  input logic [W-1:0]  head,
  input logic [W-1:0]  tail,
  input logic [AW-1:0] cnt
);

  // R2
  hi_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && reg_sel && !armed && !arm_set && !arm_clr |=> $stable(head) && $stable(tail));

  // R4
  write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !rd_en && !armed && !arm_set && !arm_clr |=> $stable(head) && $stable(tail));

  // R5
  full_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && cap_stb && !arm_set && !arm_clr && cnt == AW'(DEPTH - 1) |=> !armed);

  // R5
  partial_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && cap_stb && !arm_set && !arm_clr && cnt != AW'(DEPTH - 1) |=> armed);

  // R6
  armed_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed && rd_en && !reg_sel && !cap_stb && !arm_set && !arm_clr |=> $stable(head) && $stable(tail));

  // R7
  profile_inject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed && rd_en && !reg_sel && !arm_set && !arm_clr |=> tail == $past(op_addr));

  // R9
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm_clr |=> !armed && $stable(head));

  // R10
  idle_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed && cap_stb && !rd_en && !arm_set |=> $stable(head) && $stable(tail));

endmodule

bind trace_fifo_rd trace_fifo_rd_chk #(.DEPTH(DEPTH), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .armed(armed), .arm_set(arm_set), .arm_clr(arm_clr),
  .cap_stb(cap_stb), .rd_en(rd_en), .wr_en(wr_en), .reg_sel(reg_sel),
  .op_addr(op_addr), .head(head), .tail(tail), .cnt(cnt)
);

// File: tb/sim_trace_fifo_rd.sv
`timescale 1ns/1ps
module sim_trace_fifo_rd;
  logic clk = 0, rst_n = 0;
  logic arm_set = 0, arm_clr = 0, evt_mode = 0, cap_stb = 0;
  logic [15:0] cap_data = 0, op_addr = 0;
  logic reg_sel = 0, rd_en = 0, wr_en = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic armed;

  int total = 0, fails = 0;
  logic [15:0] m [8];
  logic marmed = 0;
  int idx = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  trace_fifo_rd u0 (.*);

  always @(negedge clk) begin
    if (rst_n && rd_en) begin
      logic [7:0] e;
      string t;
      total++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL %s read with empty scoreboard: got %h expected none", "R3", rd_data);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          fails++;
          $display("FAIL %s rd_data got %h expected %h", t, rd_data, e);
        end
      end
    end
  end

  task automatic rd(input logic sel, input string t);
    exp_q.push_back(sel ? (evt_mode ? 8'h00 : m[0][15:8]) : m[0][7:0]);
    tag_q.push_back(t);
    rd_en = 1; reg_sel = sel;
    @(posedge clk);
    if (!sel && !marmed) begin
      for (int i = 0; i < 7; i++) m[i] = m[i+1];
      m[7] = op_addr;
    end
    #1 rd_en = 0; reg_sel = 0;
  endtask

  task automatic rd_word(input string t);
    rd(1'b1, t);
    rd(1'b0, t);
  endtask

  task automatic cap(input logic [15:0] d);
    cap_stb = 1; cap_data = d;
    @(posedge clk);
    if (marmed) begin
      m[idx] = evt_mode ? {8'h00, d[7:0]} : d;
      if (idx == 7) begin marmed = 0; idx = 0; end
      else idx++;
    end
    #1 cap_stb = 0;
  endtask

  task automatic arm();
    arm_set = 1; @(posedge clk); marmed = 1; idx = 0; #1 arm_set = 0;
  endtask

  task automatic disarm();
    arm_clr = 1; @(posedge clk); marmed = 0; idx = 0; #1 arm_clr = 0;
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    wr_en = 1; reg_sel = sel; wr_data = d;
    @(posedge clk); #1 wr_en = 0; reg_sel = 0;
  endtask

  task automatic chk_armed(input logic e, input string t);
    total++;
    if (armed !== e) begin
      fails++;
      $display("FAIL %s armed got %b expected %b", t, armed, e);
    end
  endtask

  initial begin
    #(8ns * 200000);
    fails++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) m[i] = 16'h0000;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk_armed(1'b0, "R1");
    // R1 / R7 profiling: first eight words are zero, then the samples return
    for (int i = 0; i < 8; i++) begin
      op_addr = 16'h1000 + 16'(i * 16'h0111);
      rd_word("R1");
    end
    for (int i = 0; i < 8; i++) begin
      op_addr = 16'h8000 + 16'(i);
      rd_word("R7");
    end
    // R2 repeated high reads do not move the head
    rd(1'b1, "R2"); rd(1'b1, "R2"); rd(1'b1, "R2");
    // R4 writes ignored
    wr(1'b0, 8'hFF); wr(1'b1, 8'hEE);
    rd_word("R4");
    // R10 capture while disarmed ignored
    cap(16'hDEAD);
    rd_word("R10");
    // R5 arm and fill eight entries
    arm();
    chk_armed(1'b1, "R9");
    for (int i = 0; i < 8; i++) begin
      cap(16'hA000 + 16'(i * 16'h0103));
      chk_armed(i == 7 ? 1'b0 : 1'b1, "R5");
    end
    for (int i = 0; i < 8; i++) begin
      op_addr = 16'h4400 + 16'(i);
      rd_word("R5");
    end
    // R6 partial capture, low reads while armed do not advance
    arm();
    cap(16'h1234); cap(16'h5678); cap(16'h9ABC);
    rd(1'b0, "R6"); rd(1'b0, "R6"); rd(1'b1, "R6");
    chk_armed(1'b1, "R6");
    // R9 clear keeps contents; clear overrides set
    arm_set = 1; arm_clr = 1; @(posedge clk); marmed = 0; idx = 0; #1 arm_set = 0; arm_clr = 0;
    chk_armed(1'b0, "R9");
    disarm();
    chk_armed(1'b0, "R9");
    rd_word("R9"); rd_word("R9"); rd_word("R3");
    // R8 byte-event mode
    evt_mode = 1;
    arm();
    for (int i = 0; i < 8; i++) cap(16'hC300 + 16'(i * 16'h0111));
    chk_armed(1'b0, "R8");
    for (int i = 0; i < 8; i++) begin
      op_addr = 16'h7700 + 16'(i);
      rd_word("R8");
    end
    evt_mode = 0;
    for (int i = 0; i < 8; i++) rd_word("R7");
    repeat (2) @(posedge clk);
    if (exp_q.size() != 0) begin
      total++; fails++;
      $display("FAIL R3 pending reads got %0d expected 0", exp_q.size());
    end
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule